// File: doc/BRIEF.md
# Double-Buffered Serial Transceiver with Combined Interrupt

This block is a full-duplex asynchronous serial transceiver that runs at a fixed 31.25 kbit/s, with the bit timing derived from the system clock frequency given as a parameter. Each direction pairs a shift register with a single byte of buffering. Software can therefore queue the next transmit byte while the current one is still shifting out. A received byte also waits in its buffer while the next frame arrives.

Frames carry one low start bit, eight data bits with the least significant bit first, and one high stop bit. The host side is a minimal register bus. A write strobe with a data byte fills the transmit buffer. A read strobe takes the received byte out of the receive buffer, and the byte is always visible on the read data port. The transmit-empty flag and the receive-full flag are combined into one interrupt line, so one handler services both directions. The receiver oversamples the line at 16 times the bit rate. It also reports a framing error and an overrun as sticky flags, which a read clears.

Top module: `duplex_uart`

## Requirements
- R1: One bit on the line lasts 16 × round(CLK_HZ / (16 × BAUD)) clock cycles. With the default 100 MHz clock that gives 3200 cycles, which is within ±1% of 31.25 kbit/s. With CLK_HZ = 2 MHz it gives 64 cycles.
- R2: Each transmitted frame is 10 bits on tx_out: a 0 start bit, then data bit 0 through data bit 7, then a 1 stop bit. The start bit begins one clock after the byte moves from the buffer into the shifter.
- R3: tx_out is 1 after reset, 1 whenever no frame is being shifted, and 1 after the last stop bit.
- R4: A write while tx_empty is 0 is ignored, and that byte never appears on tx_out. A buffered byte moves into the shifter as soon as the shifter finishes, so consecutive frames follow with no idle time between them.
- R5: tx_empty is 1 when the transmit buffer holds no byte. It reads 0 in the cycle after an accepted write, and it returns to 1 in the cycle after the byte moves into the shifter.
- R6: After the stop bit of a valid frame is sampled, rx_full is 1 and rd_data shows the byte. A pulse on rd_en clears rx_full in the next cycle.
- R7: irq is 1 exactly when tx_empty is 1 or rx_full is 1, in the same cycle as the flag.
- R8: The receiver confirms the start bit at the middle of the bit. A low pulse shorter than half a bit is discarded, and no byte or error results from it.
- R9: A stop bit sampled as 0 sets frame_err and discards the byte, leaving rx_full and rd_data unchanged. A pulse on rd_en clears frame_err.
- R10: A valid byte that completes while rx_full is 1 and rd_en is 0 sets overrun. The new byte is dropped and the byte already held is kept. A pulse on rd_en clears overrun.
- R11: After reset: tx_out = 1, tx_empty = 1, rx_full = 0, frame_err = 0, overrun = 0, irq = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, applied synchronously |
| wr_en | input | 1 | One-cycle strobe that writes wr_data into the transmit buffer |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | One-cycle strobe that removes the received byte and clears the error flags |
| rd_data | output | 8 | Byte held in the receive buffer |
| rx_in | input | 1 | Serial receive line, asynchronous to clk |
| tx_out | output | 1 | Serial transmit line |
| tx_empty | output | 1 | Transmit buffer can accept a byte |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| frame_err | output | 1 | Sticky: a frame ended with a low stop bit |
| overrun | output | 1 | Sticky: a byte arrived while the buffer was full |
| irq | output | 1 | Shared interrupt for both directions |

## Verification
A transmit shifter left in a wrong state shows up on tx_out within one bit time. It would appear as a start bit that lasts the wrong number of cycles, a data bit out of order, a missing stop bit, or a gap between queued frames. A wrong buffer flag shows up on tx_empty, rx_full or irq in the cycle after the write, read or load that should have changed it. A receiver with a wrong phase or bit count shows up by the end of the frame. It would present a wrong byte on rd_data, or raise frame_err or overrun where neither belongs. Glitches, low stop bits and unread bytes are driven on purpose so that each of these paths is exercised at the ports.

// File: rtl/dbu_pkg.sv
package dbu_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  // clocks per oversampling tick, rounded to the nearest integer
  function automatic int unsigned tick_div(input int unsigned clk_hz,
                                           input int unsigned baud,
                                           input int unsigned ovs);
    int unsigned den;
    den = baud * ovs;
    return (clk_hz + den / 2) / den;
  endfunction

  // clocks per serial bit
  function automatic int unsigned bit_clocks(input int unsigned clk_hz,
                                             input int unsigned baud,
                                             input int unsigned ovs);
    return tick_div(clk_hz, baud, ovs) * ovs;
  endfunction

  // width of a counter that must reach n-1
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/dbu_pacer.sv
module dbu_pacer #(
  parameter int unsigned PERIOD = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = dbu_pkg::cnt_width(PERIOD);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/dbu_tx.sv
module dbu_tx #(
  parameter int unsigned DW       = 8,
  parameter int unsigned BIT_CLKS = 3200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          tx_out,
  output logic          tx_empty,
  output logic          load_ev,
  output logic          busy
);
  localparam int unsigned FW = DW + 2;
  localparam int unsigned IW = dbu_pkg::cnt_width(FW);
  localparam logic [IW-1:0] LAST_IDX = IW'(FW - 1);

  logic          hold_v;
  logic [DW-1:0] hold_d;
  logic [FW-1:0] sreg;
  logic [IW-1:0] idx;
  logic          busy_q;
  logic          bit_tick;
  logic          last_bit;
  logic          wr_acc;

  dbu_pacer #(.PERIOD(BIT_CLKS)) u_bit (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy_q),
    .tick (bit_tick)
  );

  assign last_bit = bit_tick && (idx == LAST_IDX);
  assign load_ev  = hold_v && (!busy_q || last_bit);
  assign wr_acc   = wr_en && !hold_v;

  // holding buffer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_d <= '0;
    end else if (wr_acc) begin
      hold_v <= 1'b1;
      hold_d <= wr_data;
    end else if (load_ev) begin
      hold_v <= 1'b0;
    end
  end

  // shifter: stop, data, start packed so bit 0 leaves first
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg   <= '1;
      idx    <= '0;
      busy_q <= 1'b0;
    end else if (load_ev) begin
      sreg   <= {1'b1, hold_d, 1'b0};
      idx    <= '0;
      busy_q <= 1'b1;
    end else if (bit_tick) begin
      sreg <= {1'b1, sreg[FW-1:1]};
      if (last_bit) busy_q <= 1'b0;
      else          idx    <= idx + 1'b1;
    end
  end

  assign tx_out   = sreg[0];
  assign tx_empty = !hold_v;
  assign busy     = busy_q;
endmodule

// File: rtl/dbu_rx.sv
module dbu_rx #(
  parameter int unsigned DW       = 8,
  parameter int unsigned OVS      = 16,
  parameter int unsigned TICK_DIV = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_in,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rx_full,
  output logic          frame_err,
  output logic          overrun,
  output logic          done_ev,
  output logic          ferr_ev
);
  import dbu_pkg::*;

  localparam int unsigned TW = cnt_width(OVS);
  localparam int unsigned BW = cnt_width(DW);
  localparam logic [TW-1:0] T_HALF = TW'(OVS / 2 - 1);
  localparam logic [TW-1:0] T_FULL = TW'(OVS - 1);
  localparam logic [BW-1:0] B_LAST = BW'(DW - 1);

  logic          s1, s2, s3;
  logic          fall;
  rx_state_e     state;
  logic [TW-1:0] tcnt;
  logic [BW-1:0] bcnt;
  logic [DW-1:0] shreg;
  logic [DW-1:0] buf_q;
  logic          full_q, ferr_q, ovr_q;
  logic          tick;
  logic          stop_samp;

  // two-stage synchroniser plus one stage for edge detection
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= rx_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign fall = s3 && !s2;

  dbu_pacer #(.PERIOD(TICK_DIV)) u_ovs (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (state != RX_IDLE),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= RX_IDLE;
      tcnt  <= '0;
      bcnt  <= '0;
      shreg <= '0;
    end else begin
      unique case (state)
        RX_IDLE: begin
          tcnt <= '0;
          bcnt <= '0;
          if (fall) state <= RX_START;
        end
        RX_START: if (tick) begin
          if (tcnt == T_HALF) begin
            tcnt  <= '0;
            state <= s2 ? RX_IDLE : RX_DATA;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        RX_DATA: if (tick) begin
          if (tcnt == T_FULL) begin
            tcnt  <= '0;
            shreg <= {s2, shreg[DW-1:1]};
            if (bcnt == B_LAST) state <= RX_STOP;
            else                bcnt  <= bcnt + 1'b1;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        RX_STOP: if (tick) begin
          if (tcnt == T_FULL) state <= RX_IDLE;
          else                tcnt  <= tcnt + 1'b1;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign stop_samp = (state == RX_STOP) && tick && (tcnt == T_FULL);
  assign done_ev   = stop_samp && s2;
  assign ferr_ev   = stop_samp && !s2;

  // receive buffer and sticky flags
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      ferr_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (rd_en) begin
        full_q <= 1'b0;
        ferr_q <= 1'b0;
        ovr_q  <= 1'b0;
      end
      if (done_ev) begin
        if (full_q && !rd_en) begin
          ovr_q <= 1'b1;
        end else begin
          buf_q  <= shreg;
          full_q <= 1'b1;
        end
      end
      if (ferr_ev) ferr_q <= 1'b1;
    end
  end

  assign rd_data   = buf_q;
  assign rx_full   = full_q;
  assign frame_err = ferr_q;
  assign overrun   = ovr_q;
endmodule

// File: rtl/duplex_uart.sv
module duplex_uart #(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int unsigned BAUD   = 31_250,
  parameter int unsigned DW     = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          rx_in,
  output logic          tx_out,
  output logic          tx_empty,
  output logic          rx_full,
  output logic          frame_err,
  output logic          overrun,
  output logic          irq
);
  localparam int unsigned TICK_DIV = dbu_pkg::tick_div(CLK_HZ, BAUD, OVS);
  localparam int unsigned BIT_CLKS = dbu_pkg::bit_clocks(CLK_HZ, BAUD, OVS);

  // named internal events, observed by the bound checker
  logic tx_load_ev;
  logic tx_busy;
  logic rx_done_ev;
  logic rx_ferr_ev;

  dbu_tx #(.DW(DW), .BIT_CLKS(BIT_CLKS)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .tx_out  (tx_out),
    .tx_empty(tx_empty),
    .load_ev (tx_load_ev),
    .busy    (tx_busy)
  );

  dbu_rx #(.DW(DW), .OVS(OVS), .TICK_DIV(TICK_DIV)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_in    (rx_in),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .rx_full  (rx_full),
    .frame_err(frame_err),
    .overrun  (overrun),
    .done_ev  (rx_done_ev),
    .ferr_ev  (rx_ferr_ev)
  );

  assign irq = tx_empty | rx_full;
endmodule

// File: rtl/duplex_uart_chk.sv
module duplex_uart_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [DW-1:0] rd_data,
  input logic          tx_out,
  input logic          tx_empty,
  input logic          rx_full,
  input logic          frame_err,
  input logic          overrun,
  input logic          tx_load_ev,
  input logic          tx_busy,
  input logic          rx_done_ev,
  input logic          rx_ferr_ev
);
  AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_out); // R3

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load_ev |=> !tx_out); // R2

  AST_WRITE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && tx_empty) |=> !tx_empty); // R5

  AST_FULL_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !tx_empty && !tx_load_ev) |=> !tx_empty); // R4

  AST_RX_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_ev |=> rx_full); // R6

  AST_RX_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rx_done_ev) |=> !rx_full); // R6

  AST_FRAME_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ferr_ev |=> frame_err); // R9

  AST_OVERRUN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done_ev && rx_full && !rd_en) |=> (overrun && $stable(rd_data))); // R10
endmodule

bind duplex_uart duplex_uart_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .rd_data   (rd_data),
  .tx_out    (tx_out),
  .tx_empty  (tx_empty),
  .rx_full   (rx_full),
  .frame_err (frame_err),
  .overrun   (overrun),
  .tx_load_ev(tx_load_ev),
  .tx_busy   (tx_busy),
  .rx_done_ev(rx_done_ev),
  .rx_ferr_ev(rx_ferr_ev)
);

// File: tb/duplex_uart_tb_top.sv
`timescale 1ns/1ps
module duplex_uart_tb_top;
  localparam int unsigned TB_CLK_HZ = 2_000_000;
  localparam int unsigned TB_BAUD   = 31_250;

  // bench's own bit length: nearest whole clocks per sixteenth, times sixteen
  function automatic int exp_bit_len(input real hz, input real baud);
    int per_tick;
    per_tick = $rtoi(hz / (baud * 16.0) + 0.5);
    return per_tick * 16;
  endfunction

  localparam int BIT = exp_bit_len(real'(TB_CLK_HZ), real'(TB_BAUD));

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       rx_in = 1'b1;
  logic       tx_out, tx_empty, rx_full, frame_err, overrun, irq;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  duplex_uart #(.CLK_HZ(TB_CLK_HZ), .BAUD(TB_BAUD)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .rx_in    (rx_in),
    .tx_out   (tx_out),
    .tx_empty (tx_empty),
    .rx_full  (rx_full),
    .frame_err(frame_err),
    .overrun  (overrun),
    .irq      (irq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic write_byte(input logic [7:0] d);
    wr_data = d;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic read_byte();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // waits for a start bit, samples every bit at its centre
  task automatic capture_frame(output logic [7:0] d, output logic st, output logic sp,
                               output int waited);
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (tx_out !== 1'b0 && waited < 40 * BIT);
    repeat (BIT / 2) @(negedge clk);
    st = tx_out;
    for (int i = 0; i < 8; i++) begin
      repeat (BIT) @(negedge clk);
      d[i] = tx_out;
    end
    repeat (BIT) @(negedge clk);
    sp = tx_out;
  endtask

  task automatic drive_frame(input logic [7:0] d, input logic stop_v);
    rx_in = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_in = d[i];
      repeat (BIT) @(negedge clk);
    end
    rx_in = stop_v;
    repeat (BIT) @(negedge clk);
    rx_in = 1'b1;
    @(negedge clk);
  endtask

  // full transmit of one byte with frame checks
  task automatic tx_one(input logic [7:0] d, input string req);
    logic [7:0] got;
    logic st, sp;
    int w;
    fork
      capture_frame(got, st, sp, w);
      write_byte(d);
    join
    chk(req, "tx start bit", int'(st), 0);
    chk(req, "tx data", int'(got), int'(d));
    chk(req, "tx stop bit", int'(sp), 1);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190_000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d, got, x, y;
    logic st, sp;
    int w, lowlen, falls;
    void'($urandom(32'h0000_5a17));

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11", "tx_out", int'(tx_out), 1);
    chk("R11", "tx_empty", int'(tx_empty), 1);
    chk("R11", "rx_full", int'(rx_full), 0);
    chk("R11", "frame_err", int'(frame_err), 0);
    chk("R11", "overrun", int'(overrun), 0);
    chk("R7", "irq after reset", int'(irq), 1);
    chk("R3", "line idle high", int'(tx_out), 1);

    // R5 / R7 flag timing around a write, R2 frame of 0x55
    fork
      capture_frame(got, st, sp, w);
      begin
        write_byte(8'h55);
        chk("R5", "tx_empty after write", int'(tx_empty), 0);
        chk("R7", "irq with no flag set", int'(irq), 0);
        @(negedge clk);
        chk("R5", "tx_empty after move to shifter", int'(tx_empty), 1);
        chk("R7", "irq follows tx_empty", int'(irq), 1);
      end
    join
    chk("R2", "start 0x55", int'(st), 0);
    chk("R2", "data 0x55", int'(got), 8'h55);
    chk("R2", "stop 0x55", int'(sp), 1);
    repeat (BIT) @(negedge clk);
    chk("R3", "line high after frame", int'(tx_out), 1);

    // R1 start bit length: 0x55 puts a 1 right after the start bit
    write_byte(8'h55);
    while (tx_out !== 1'b0) @(negedge clk);
    lowlen = 0;
    while (tx_out === 1'b0 && lowlen < 4 * BIT) begin
      @(negedge clk);
      lowlen++;
    end
    chk("R1", "start bit cycles", lowlen, BIT);
    repeat (10 * BIT) @(negedge clk);

    // R2 random bytes
    for (int k = 0; k < 6; k++) begin
      d = 8'($urandom);
      tx_one(d, "R2");
      repeat (BIT) @(negedge clk);
    end

    // R4 back-to-back frames and a write into a full buffer
    fork
      begin
        capture_frame(got, st, sp, w);
        chk("R4", "first queued byte", int'(got), 8'hC3);
        capture_frame(got, st, sp, w);
        chk("R4", "second frame follows without gap", w, BIT / 2);
        chk("R4", "second queued byte", int'(got), 8'h1E);
        chk("R4", "second stop", int'(sp), 1);
      end
      begin
        write_byte(8'hC3);
        @(negedge clk);
        write_byte(8'h1E);
        chk("R5", "tx_empty with byte queued", int'(tx_empty), 0);
        write_byte(8'hFF);
        chk("R4", "tx_empty after ignored write", int'(tx_empty), 0);
      end
    join
    falls = 0;
    for (int c = 0; c < 14 * BIT; c++) begin
      @(negedge clk);
      if (tx_out === 1'b0) falls++;
    end
    chk("R4", "ignored byte never sent", falls, 0);
    chk("R3", "line high after queue drained", int'(tx_out), 1);

    // R6 receive random bytes
    for (int k = 0; k < 6; k++) begin
      d = 8'($urandom);
      drive_frame(d, 1'b1);
      chk("R6", "rx_full after frame", int'(rx_full), 1);
      chk("R6", "rd_data", int'(rd_data), int'(d));
      chk("R7", "irq with rx_full", int'(irq), 1);
      read_byte();
      chk("R6", "rx_full after read", int'(rx_full), 0);
      repeat ($urandom_range(BIT, 1)) @(negedge clk);
    end

    // R8 short low glitch
    rx_in = 1'b0;
    repeat (BIT / 3) @(negedge clk);
    rx_in = 1'b1;
    repeat (12 * BIT) @(negedge clk);
    chk("R8", "glitch gives no byte", int'(rx_full), 0);
    chk("R8", "glitch gives no error", int'(frame_err), 0);
    drive_frame(8'h81, 1'b1);
    chk("R8", "frame after glitch", int'(rd_data), 8'h81);
    read_byte();

    // R9 low stop bit
    drive_frame(8'hA5, 1'b0);
    chk("R9", "frame_err set", int'(frame_err), 1);
    chk("R9", "bad byte discarded", int'(rx_full), 0);
    chk("R9", "rd_data unchanged", int'(rd_data), 8'h81);
    drive_frame(8'h3C, 1'b1);
    chk("R9", "next frame after error", int'(rd_data), 8'h3C);
    chk("R9", "frame_err stays until read", int'(frame_err), 1);
    read_byte();
    chk("R9", "frame_err cleared by read", int'(frame_err), 0);

    // R10 overrun
    x = 8'($urandom);
    y = ~x;
    drive_frame(x, 1'b1);
    drive_frame(y, 1'b1);
    chk("R10", "overrun set", int'(overrun), 1);
    chk("R10", "old byte kept", int'(rd_data), int'(x));
    chk("R10", "still full", int'(rx_full), 1);
    read_byte();
    chk("R10", "overrun cleared by read", int'(overrun), 0);
    chk("R6", "empty after read", int'(rx_full), 0);
    drive_frame(8'h6E, 1'b1);
    chk("R10", "byte after overrun", int'(rd_data), 8'h6E);
    chk("R10", "no overrun when read in time", int'(overrun), 0);
    read_byte();

    finish_run();
  end
endmodule